// File: doc/BRIEF.md
# Interrupt Routing Table Controller

The block gathers 32 peripheral interrupt lines and turns each of them into a vectored request for one or more hardware threads. Software programs a routing table over a small word-addressed register bus. Each table entry has two words. The first is a one-hot-per-thread destination mask. The second is a control word that holds two enable flags, a scheduling hint and a 6-bit vector. Each thread gets a pending flag, an 8-bit vector and an NMI flag. When several routed entries are pending at one thread, the lowest-numbered entry is presented. The thread clears it by writing a one to that entry's bit in the acknowledge register.

Entries 1 to 8 carry timer events and latch on a rising edge. Every other entry is level-sensitive. A separate inter-processor interrupt (IPI) register lets software inject a vector, optionally flagged as NMI, into any single thread for one cycle. The raw input lines and the per-entry pending state can both be read back, whether or not an entry is enabled.

Top module: `irq_router`

## Requirements
- R1: After reset every thread output is 0, and the mask words, control words, pending word (0x06) and raw-input word (0x07) all read as zero.
- R2: The mask word of entry i is at word address 0x40+i, with bit t meaning thread t. The control word of entry i is at 0x80+i. The control word keeps bit 31 (valid), bit 30 (enable), bit 6 (local scheduling) and bits [5:0] (vector); all other bits read as zero.
- R3: An entry raises pending only when its valid and enable bits are both set. Otherwise its pending bit is cleared within one cycle and never reaches any thread.
- R4: A level entry (entries 0 and 9 to 31) becomes pending one cycle after its input is sampled high. An acknowledge clears it for the following cycle, and it re-asserts one cycle later if the input is still high.
- R5: An edge entry (entries 1 to 8) becomes pending one cycle after a rising input edge and stays pending after the input falls, until it is acknowledged. A rising edge in the acknowledge cycle keeps it pending.
- R6: A write to word address 0x06 clears the pending bit of every entry i whose data bit i is 1. Zero bits have no effect.
- R7: A pending entry is presented to every thread whose bit is set in its mask.
- R8: At each thread the lowest-numbered pending entry wins. Its control-word bits [5:0], zero-extended to 8 bits, appear on that thread's vector.
- R9: A write to word address 0x04 targets thread core*4+thread, with core in data bits [22:20] and thread in bits [17:16]. In the next cycle only, that thread shows pending with vector equal to data bits [7:0].
- R10: During its cycle an IPI overrides any routed entry at its target thread. NMI is asserted only for an IPI whose data bit 8 is set.
- R11: Word address 0x07 reads the input lines as sampled at the last clock edge, for enabled and disabled entries alike. Word address 0x06 reads the per-entry pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Peripheral interrupt lines, one per entry |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Word address for reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| pend_o | output | 32 | Per-thread interrupt pending |
| vec_o | output | 256 | Per-thread vector, thread t in bits [8t+7:8t] |
| nmi_o | output | 32 | Per-thread NMI flag |

## Verification
Some properties are checked by assertions on every cycle. A disabled entry always has its pending bit dropped within a cycle. An acknowledge always clears a level entry. An enabled, unacknowledged edge entry never loses its pending bit. An IPI always reaches its target thread in the following cycle, and NMI never appears without an IPI write that requested it. Other behaviour is shown only by the bench scenarios, which compare every cycle against a reference model. These cover the lowest-index choice when several entries share a thread, fan-out of one entry to several threads, re-assertion of a still-high level input, an edge that arrives during its own acknowledge, and the IPI overriding a routed vector for exactly one cycle.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int AW   = 8;
  localparam int DW   = 32;
  localparam int VW   = 8;
  localparam int CVW  = 6;

  localparam logic [AW-1:0] A_IPI  = 8'h04;
  localparam logic [AW-1:0] A_ACK  = 8'h06;
  localparam logic [AW-1:0] A_RAW  = 8'h07;
  localparam logic [AW-1:0] A_MASK = 8'h40;
  localparam logic [AW-1:0] A_CTRL = 8'h80;

  typedef struct packed {
    logic           valid;
    logic           en;
    logic           local_s;
    logic [CVW-1:0] vec;
  } ctrl_t;

  typedef struct packed {
    logic          hit;
    logic [4:0]    thr;
    logic          nmi;
    logic [VW-1:0] vec;
  } ipi_t;

  function automatic logic [DW-1:0] ctrl_pack(ctrl_t c);
    logic [DW-1:0] w;
    w = '0;
    w[31] = c.valid;
    w[30] = c.en;
    w[6]  = c.local_s;
    w[CVW-1:0] = c.vec;
    return w;
  endfunction

  function automatic ctrl_t ctrl_unpack(logic [DW-1:0] w);
    ctrl_t c;
    c.valid   = w[31];
    c.en      = w[30];
    c.local_s = w[6];
    c.vec     = w[CVW-1:0];
    return c;
  endfunction
endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_router_pkg::*;
#(
  parameter int N_SRC = 32,
  parameter int N_THR = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_i,
  input  logic [AW-1:0]                addr_i,
  input  logic [DW-1:0]                wdata_i,
  input  logic [N_SRC-1:0]             ent_pend_i,
  input  logic [N_SRC-1:0]             raw_i,
  output logic [N_SRC-1:0][N_THR-1:0]  mask_o,
  output ctrl_t [N_SRC-1:0]            ctrl_o,
  output logic [DW-1:0]                rdata_o
);
  logic [N_SRC-1:0][N_THR-1:0] mask_q;
  ctrl_t [N_SRC-1:0]           ctrl_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_ent
    localparam logic [AW-1:0] MA = A_MASK + AW'(i);
    localparam logic [AW-1:0] CA = A_CTRL + AW'(i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_q[i] <= '0;
        ctrl_q[i] <= '0;
      end else if (wr_i) begin
        if (addr_i == MA) mask_q[i] <= wdata_i[N_THR-1:0];
        if (addr_i == CA) ctrl_q[i] <= ctrl_unpack(wdata_i);
      end
    end

    // R2
    mask_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i == MA) |=> (mask_q[i] == $past(wdata_i[N_THR-1:0])));
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_ACK) rdata_o[N_SRC-1:0] = ent_pend_i;
    if (addr_i == A_RAW) rdata_o[N_SRC-1:0] = raw_i;
    for (int i = 0; i < N_SRC; i++) begin
      if (addr_i == A_MASK + AW'(i)) rdata_o[N_THR-1:0] = mask_q[i];
      if (addr_i == A_CTRL + AW'(i)) rdata_o = ctrl_pack(ctrl_q[i]);
    end
  end

  assign mask_o = mask_q;
  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/irq_entry_bank.sv
module irq_entry_bank #(
  parameter int N_SRC   = 32,
  parameter int EDGE_LO = 1,
  parameter int EDGE_HI = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] act_i,
  input  logic [N_SRC-1:0] ack_i,
  output logic [N_SRC-1:0] pend_o,
  output logic [N_SRC-1:0] raw_o
);
  logic [N_SRC-1:0] raw_q;
  logic [N_SRC-1:0] pend_q;
  logic [N_SRC-1:0] pend_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= '0;
      pend_q <= '0;
    end else begin
      raw_q  <= src_i;
      pend_q <= pend_d;
    end
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_ent
    if (i >= EDGE_LO && i <= EDGE_HI) begin : g_edge
      // new edge beats a concurrent ack so no event is lost
      assign pend_d[i] = act_i[i] & ((src_i[i] & ~raw_q[i]) | (pend_q[i] & ~ack_i[i]));

      // R5
      edge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_q[i] && act_i[i] && !ack_i[i]) |=> pend_q[i]);
      // R6
      edge_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i[i] && !(src_i[i] && !raw_q[i])) |=> !pend_q[i]);
    end else begin : g_level
      // ack wins for one cycle; a still-high line re-arms after it
      assign pend_d[i] = act_i[i] & ~ack_i[i] & (pend_q[i] | src_i[i]);

      // R4
      level_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_i[i] |=> !pend_q[i]);
    end

    // R3
    inactive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !act_i[i] |=> !pend_q[i]);
  end

  assign pend_o = pend_q;
  assign raw_o  = raw_q;
endmodule

// File: rtl/irq_ipi.sv
module irq_ipi
  import irq_router_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic [2:0]    core_i,
  input  logic [1:0]    thr_i,
  input  logic          nmi_i,
  input  logic [VW-1:0] vec_i,
  output ipi_t          ipi_o
);
  ipi_t ipi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ipi_q <= '0;
    end else begin
      ipi_q.hit <= fire_i;
      ipi_q.thr <= {core_i, thr_i};
      ipi_q.nmi <= fire_i & nmi_i;
      ipi_q.vec <= vec_i;
    end
  end

  assign ipi_o = ipi_q;
endmodule

// File: rtl/irq_thread_sel.sv
module irq_thread_sel
  import irq_router_pkg::*;
#(
  parameter int N_SRC = 32,
  parameter int N_THR = 32
) (
  input  logic [N_SRC-1:0]            ent_pend_i,
  input  logic [N_SRC-1:0][N_THR-1:0] mask_i,
  input  logic [N_SRC-1:0][CVW-1:0]   vec_i,
  input  ipi_t                        ipi_i,
  output logic [N_THR-1:0]            pend_o,
  output logic [N_THR*VW-1:0]         vec_o,
  output logic [N_THR-1:0]            nmi_o
);
  for (genvar t = 0; t < N_THR; t++) begin : g_thr
    logic           hit;
    logic [CVW-1:0] vsel;
    logic           ipi_here;

    assign ipi_here = ipi_i.hit && (ipi_i.thr == 5'(t));

    // descending scan leaves the lowest index as the final winner
    always_comb begin
      hit  = 1'b0;
      vsel = '0;
      for (int i = N_SRC - 1; i >= 0; i--) begin
        if (ent_pend_i[i] && mask_i[i][t]) begin
          hit  = 1'b1;
          vsel = vec_i[i];
        end
      end
    end

    always_comb begin
      pend_o[t]           = 1'b0;
      nmi_o[t]            = 1'b0;
      vec_o[t*VW +: VW]   = '0;
      if (ipi_here) begin
        pend_o[t]         = 1'b1;
        nmi_o[t]          = ipi_i.nmi;
        vec_o[t*VW +: VW] = ipi_i.vec;
      end else if (hit) begin
        pend_o[t]         = 1'b1;
        vec_o[t*VW +: VW] = {{(VW-CVW){1'b0}}, vsel};
      end
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int N_SRC   = 32,
  parameter int N_THR   = 32,
  parameter int EDGE_LO = 1,
  parameter int EDGE_HI = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_SRC-1:0]    src_i,
  input  logic                wr_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [DW-1:0]       rdata_o,
  output logic [N_THR-1:0]    pend_o,
  output logic [N_THR*VW-1:0] vec_o,
  output logic [N_THR-1:0]    nmi_o
);
  logic [N_SRC-1:0][N_THR-1:0] mask;
  ctrl_t [N_SRC-1:0]           ctrl;
  logic [N_SRC-1:0][CVW-1:0]   cvec;
  logic [N_SRC-1:0]            act;
  logic [N_SRC-1:0]            ack;
  logic [N_SRC-1:0]            ent_pend;
  logic [N_SRC-1:0]            raw;
  logic                        ipi_fire;
  ipi_t                        ipi;

  for (genvar i = 0; i < N_SRC; i++) begin : g_act
    assign act[i]  = ctrl[i].valid & ctrl[i].en;
    assign cvec[i] = ctrl[i].vec;
  end

  assign ack      = (wr_i && addr_i == A_ACK) ? wdata_i[N_SRC-1:0] : '0;
  assign ipi_fire = wr_i && addr_i == A_IPI;

  irq_regfile #(.N_SRC(N_SRC), .N_THR(N_THR)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .ent_pend_i (ent_pend),
    .raw_i      (raw),
    .mask_o     (mask),
    .ctrl_o     (ctrl),
    .rdata_o    (rdata_o)
  );

  irq_entry_bank #(.N_SRC(N_SRC), .EDGE_LO(EDGE_LO), .EDGE_HI(EDGE_HI)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .act_i  (act),
    .ack_i  (ack),
    .pend_o (ent_pend),
    .raw_o  (raw)
  );

  irq_ipi u_ipi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (ipi_fire),
    .core_i (wdata_i[22:20]),
    .thr_i  (wdata_i[17:16]),
    .nmi_i  (wdata_i[8]),
    .vec_i  (wdata_i[VW-1:0]),
    .ipi_o  (ipi)
  );

  irq_thread_sel #(.N_SRC(N_SRC), .N_THR(N_THR)) u_sel (
    .ent_pend_i (ent_pend),
    .mask_i     (mask),
    .vec_i      (cvec),
    .ipi_i      (ipi),
    .pend_o     (pend_o),
    .vec_o      (vec_o),
    .nmi_o      (nmi_o)
  );

  // R9
  ipi_deliver_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_IPI) |=>
      pend_o[5'({$past(wdata_i[22:20]), $past(wdata_i[17:16])})]);
  // R10
  nmi_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|nmi_o) |-> $past(wr_i && addr_i == A_IPI && wdata_i[8]));
  // R10
  nmi_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(nmi_o));
  // R7
  idle_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ent_pend == '0 && !ipi.hit) |-> (pend_o == '0));
endmodule

// File: tb/irq_router_bench.sv
`timescale 1ns/1ps
module irq_router_bench;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   src = '0;
  logic          wr = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [31:0]   pend;
  logic [255:0]  vec;
  logic [31:0]   nmi;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_router u_irq_router (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pend_o(pend), .vec_o(vec), .nmi_o(nmi)
  );

  // reference model state
  logic [31:0] m_mask [32];
  logic [31:0] m_ctrl [32];
  logic [31:0] m_ep, m_srcq;
  logic        m_ipi;
  logic [4:0]  m_ithr;
  logic [7:0]  m_ivec;
  logic        m_inmi;
  string       tag = "R1";

  function automatic logic [31:0] keep_ctrl(logic [31:0] w);
    return w & 32'hC000_007F;
  endfunction

  function automatic bit is_edge(int i);
    return (i >= 1 && i <= 8);
  endfunction

  task automatic chk(bit ok, string t, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", t, act, exp);
    end
  endtask

  task automatic check_outs();
    logic [31:0]  ep, en;
    logic [255:0] ev;
    ep = '0; en = '0; ev = '0;
    for (int t = 0; t < 32; t++) begin
      if (m_ipi && m_ithr == 5'(t)) begin
        ep[t] = 1'b1; en[t] = m_inmi; ev[t*8 +: 8] = m_ivec;
      end else begin
        for (int i = 31; i >= 0; i--)
          if (m_ep[i] && m_mask[i][t]) begin
            ep[t] = 1'b1; ev[t*8 +: 8] = {2'b00, m_ctrl[i][5:0]};
          end
      end
    end
    chk(pend == ep, {tag, " pend"}, 256'(pend), 256'(ep));
    chk(vec == ev,  {tag, " vec"},  vec, ev);
    chk(nmi == en,  {tag, " nmi"},  256'(nmi), 256'(en));
  endtask

  task automatic step();
    logic [31:0] ack, rise, nx;
    ack  = (wr && addr == 8'h06) ? wdata : '0;
    rise = src & ~m_srcq;
    for (int i = 0; i < 32; i++) begin
      bit a;
      a = m_ctrl[i][31] & m_ctrl[i][30];
      if (is_edge(i)) nx[i] = a & (rise[i] | (m_ep[i] & ~ack[i]));
      else            nx[i] = a & ~ack[i] & (m_ep[i] | src[i]);
    end
    @(posedge clk);
    m_ep   = nx;
    m_srcq = src;
    m_ipi  = wr && addr == 8'h04;
    m_ithr = {wdata[22:20], wdata[17:16]};
    m_ivec = wdata[7:0];
    m_inmi = wdata[8];
    if (wr && addr >= 8'h40 && addr < 8'h60) m_mask[addr - 8'h40] = wdata;
    if (wr && addr >= 8'h80 && addr < 8'hA0) m_ctrl[addr - 8'h80] = keep_ctrl(wdata);
    @(negedge clk);
    wr = 1'b0;
    check_outs();
  endtask

  task automatic wr_reg(logic [7:0] a, logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    step();
  endtask

  task automatic rd_chk(logic [7:0] a, logic [31:0] exp, string t);
    addr = a;
    #1;
    chk(rdata == exp, t, 256'(rdata), 256'(exp));
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 32; i++) begin m_mask[i] = '0; m_ctrl[i] = '0; end
    m_ep = '0; m_srcq = '0; m_ipi = 0; m_ithr = '0; m_ivec = '0; m_inmi = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    tag = "R1";
    check_outs();
    rd_chk(8'h40, 32'h0, "R1 mask0");
    rd_chk(8'h9F, 32'h0, "R1 ctrl31");
    rd_chk(8'h06, 32'h0, "R1 pend");
    rd_chk(8'h07, 32'h0, "R1 raw");

    // R2 readback and field masking
    tag = "R2";
    wr_reg(8'h45, 32'hA5A5_0F0F);
    wr_reg(8'h85, 32'hFFFF_FFFF);
    rd_chk(8'h45, 32'hA5A5_0F0F, "R2 mask5");
    rd_chk(8'h85, 32'hC000_007F, "R2 ctrl5");
    wr_reg(8'h85, 32'h0);

    // R3 valid without enable, R11 raw readback
    tag = "R3";
    wr_reg(8'h4C, 32'h0000_0008);
    wr_reg(8'h8C, 32'h8000_0009);
    src[12] = 1'b1;
    idle(3);
    chk(pend[3] == 1'b0, "R3 not enabled", 256'(pend[3]), 256'(0));
    rd_chk(8'h07, 32'h0000_1000, "R11 raw");
    rd_chk(8'h06, 32'h0, "R11 pend");
    wr_reg(8'h8C, 32'hC000_0009);
    step();
    chk(pend[3] == 1'b1, "R3 enabled", 256'(pend[3]), 256'(1));
    chk(vec[31:24] == 8'h09, "R8 vector", 256'(vec[31:24]), 256'(9));

    // R4 level ack and re-arm
    tag = "R4";
    wr_reg(8'h06, 32'h0000_1000);
    chk(pend[3] == 1'b0, "R4 ack clears", 256'(pend[3]), 256'(0));
    step();
    chk(pend[3] == 1'b1, "R4 rearm", 256'(pend[3]), 256'(1));
    src[12] = 1'b0;
    tag = "R6";
    wr_reg(8'h06, 32'hFFFF_EFFF);
    chk(pend[3] == 1'b1, "R6 zero bit ignored", 256'(pend[3]), 256'(1));
    wr_reg(8'h06, 32'h0000_1000);
    idle(2);
    chk(pend[3] == 1'b0, "R4 stays low", 256'(pend[3]), 256'(0));

    // R5 edge latch, hold and ack collision
    tag = "R5";
    wr_reg(8'h43, 32'h0000_0080);
    wr_reg(8'h83, 32'hC000_0021);
    src[3] = 1'b1; step();
    src[3] = 1'b0; idle(4);
    chk(pend[7] == 1'b1, "R5 held", 256'(pend[7]), 256'(1));
    wr_reg(8'h06, 32'h0000_0008);
    chk(pend[7] == 1'b0, "R5 ack", 256'(pend[7]), 256'(0));
    src[3] = 1'b1; wr_reg(8'h06, 32'h0000_0008);
    chk(pend[7] == 1'b1, "R5 edge beats ack", 256'(pend[7]), 256'(1));
    src[3] = 1'b0; wr_reg(8'h06, 32'h0000_0008);

    // R7 fan-out, R8 priority
    tag = "R7";
    wr_reg(8'h54, 32'h0001_0101);
    wr_reg(8'h94, 32'hC000_0014);
    src[20] = 1'b1; idle(2);
    chk(pend[0] && pend[8] && pend[16], "R7 fan-out", 256'(pend), 256'(32'h0001_0101));
    tag = "R8";
    wr_reg(8'h4C, 32'h0000_0100);
    src[12] = 1'b1; idle(2);
    chk(vec[71:64] == 8'h09, "R8 lowest wins", 256'(vec[71:64]), 256'(9));

    // R9/R10 IPI
    tag = "R9";
    wr_reg(8'h04, 32'h0021_015A);
    chk(pend[9] && vec[79:72] == 8'h5A && nmi[9], "R9 ipi", 256'(vec[79:72]), 256'(8'h5A));
    step();
    chk(pend[9] == 1'b0, "R9 one cycle", 256'(pend[9]), 256'(0));
    tag = "R10";
    wr_reg(8'h04, 32'h0020_0033);
    chk(vec[71:64] == 8'h33 && nmi[8] == 1'b0, "R10 ipi overrides", 256'(vec[71:64]), 256'(8'h33));
    step();
    chk(vec[71:64] == 8'h09, "R10 entry returns", 256'(vec[71:64]), 256'(9));

    // random
    tag = "R8 random";
    for (int i = 0; i < 32; i++) begin
      logic [31:0] m;
      m = $urandom() & $urandom() & $urandom();
      wr_reg(8'h40 + 8'(i), m);
      wr_reg(8'h80 + 8'(i), {($urandom_range(0, 3) != 0), ($urandom_range(0, 4) != 0), 23'h0, 7'($urandom())});
    end
    for (int k = 0; k < 600; k++) begin
      src = $urandom() & $urandom();
      case ($urandom_range(0, 9))
        0: begin wr = 1; addr = 8'h06; wdata = $urandom(); end
        1: begin wr = 1; addr = 8'h04; wdata = $urandom(); end
        2: begin wr = 1; addr = 8'h80 + 8'($urandom_range(0, 31)); wdata = $urandom(); end
        default: wr = 0;
      endcase
      step();
    end
    rd_chk(8'h06, m_ep, "R11 pend random");
    rd_chk(8'h07, m_srcq, "R11 raw random");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule